// File: doc/BRIEF.md
# IN Endpoint Transmit FIFO with Packet Admission

This block is the transmit buffer for one IN endpoint of a USB device. Software announces each packet with its length in 32-bit words. The block accepts the packet only if all of it fits into the space that is still free. It then takes the data words one per cycle. Zero-length packets are taken without looking at free space. The endpoint must be enabled both when a packet is announced and when its words are written.

Several packets can wait in the buffer at once. Their boundaries are kept in a small length queue, so the transmit engine always sees whole packets, zero-length ones included. When the endpoint is periodic, only one packet can be outstanding at a time. After that, new announcements are refused until the transfer-complete pulse arrives.

Software can read the free space in words. It can also wait for a sticky empty interrupt, which it clears by writing one. A flush input clears all queued content in a single cycle.

Top module: `txf_in_ep`

## Requirements
- R1: A packet announcement (`pkt_start`) with non-zero length is accepted only when `pkt_len <= free_words` and the length queue has a free slot. The result is a one-cycle pulse on `pkt_ok` or `pkt_rej` in the following cycle. A refused packet stores nothing.
- R2: A zero-length announcement (`pkt_len` = 0) is accepted even when `free_words` is 0. Its entry can be drained at once with `tx_len` = 0 and `tx_last` = 1.
- R3: `free_words` equals the word depth minus the words stored minus the words still owed by the open packet. Space is reserved for the whole packet when it is accepted.
- R4: With `ep_enable` low, an announcement is refused. A data word offered in that state is dropped, leaves `free_words` unchanged, and raises `wr_err` for one cycle.
- R5: Several accepted packets queue up. They drain in order, one word per `tx_rd`. `tx_len` gives the length of the head packet, and `tx_last` marks its final word.
- R6: While `ep_periodic` is high, a second announcement is refused after one packet has been accepted. The gate reopens after a `xfer_done` pulse.
- R7: A data word offered when no packet is open is dropped and raises `wr_err` one cycle later. This covers a word beyond the declared length.
- R8: `irq_empty` sets when a drain read removes the last stored item. It holds until a pulse on `irq_clr`. If a set and a clear fall in the same cycle, the set wins.
- R9: `tx_rd` has no effect while no complete packet is queued (`tx_avail` low). This holds even while a partial packet is being written.
- R10: `flush` empties the data and length queues within one cycle. It also cancels an open packet and reopens the periodic gate, and it does not set `irq_empty`.
- R11: An announcement made while a packet is still open is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty all queues and cancel the open packet |
| ep_enable | input | 1 | Endpoint enable |
| ep_periodic | input | 1 | Endpoint is periodic (one packet per transaction) |
| xfer_done | input | 1 | Transfer-complete pulse for the outstanding periodic packet |
| pkt_start | input | 1 | Packet announcement strobe |
| pkt_len | input | LEN_W | Announced packet length in words |
| pkt_ok | output | 1 | Announcement accepted (one cycle later) |
| pkt_rej | output | 1 | Announcement refused (one cycle later) |
| wr_valid | input | 1 | Data word strobe |
| wr_data | input | WORD_W | Data word |
| wr_err | output | 1 | Dropped-word error pulse |
| free_words | output | LEN_W | Free space in words |
| tx_avail | output | 1 | A complete packet is queued |
| tx_len | output | LEN_W | Length of head packet |
| tx_data | output | WORD_W | Current head word |
| tx_last | output | 1 | Current read ends the head packet |
| tx_rd | input | 1 | Drain read strobe |
| irq_empty | output | 1 | Sticky empty interrupt |
| irq_clr | input | 1 | Write-one-to-clear for `irq_empty` |

## Verification
Two functions can meet in the same cycle: the drain read that removes the last queued word, which sets the empty interrupt, and the software clear of that interrupt. The bench queues a one-word packet. It then drives `tx_rd` and `irq_clr` in the same cycle and expects `irq_empty` to be high afterwards. A later lone clear must drop it. The bench also drives data writes and periodic gating back to back with drains, and judges `free_words` and the drained words against values computed from the announced lengths.

// File: rtl/txf_pkg.sv
package txf_pkg;

   localparam int WORD_BITS = 32;

   typedef enum logic [1:0] {
      ADM_IDLE   = 2'd0,
      ADM_TAKE   = 2'd1,
      ADM_REFUSE = 2'd2
   } adm_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/txf_ring.sv
module txf_ring #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   import txf_pkg::*;

   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("txf_ring: DEPTH must be a power of two >= 2");
      end
      if (W < 1) begin : g_bad_width
         $error("txf_ring: W must be positive");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !flush) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   AST_RING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |-> !full);   // R1
   AST_RING_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty);   // R9

endmodule

// File: rtl/txf_admit.sv
module txf_admit
   import txf_pkg::*;
#(
   parameter int DEPTH_WORDS = 16,
   localparam int LEN_W = $clog2(DEPTH_WORDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             ep_enable,
   input  logic             ep_periodic,
   input  logic             xfer_done,
   input  logic             pkt_start,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             wr_valid,
   input  logic [LEN_W-1:0] free_words,
   input  logic             slot_full,
   output logic             word_we,
   output logic             lq_push,
   output logic [LEN_W-1:0] lq_push_len,
   output logic [LEN_W-1:0] rem_words,
   output logic             pkt_ok,
   output logic             pkt_rej,
   output logic             wr_err
);

   logic             open_q;
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] len_q;
   logic             gate_q;
   adm_e             res_q;
   logic             err_q;

   logic start_ok, is_zlp, fits, last_word;

   assign is_zlp    = (pkt_len == '0);
   assign fits      = is_zlp || (pkt_len <= free_words);
   assign start_ok  = pkt_start && !flush && ep_enable && !open_q && !slot_full
                      && !(ep_periodic && gate_q) && fits;
   assign word_we   = wr_valid && open_q && ep_enable && !flush;
   assign last_word = word_we && (rem_q == LEN_W'(1));

   assign lq_push     = (start_ok && is_zlp) || last_word;
   assign lq_push_len = last_word ? len_q : '0;
   assign rem_words   = rem_q;

   assign pkt_ok  = (res_q == ADM_TAKE);
   assign pkt_rej = (res_q == ADM_REFUSE);
   assign wr_err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         rem_q  <= '0;
         len_q  <= '0;
      end else if (flush) begin
         open_q <= 1'b0;
         rem_q  <= '0;
         len_q  <= '0;
      end else if (start_ok && !is_zlp) begin
         open_q <= 1'b1;
         rem_q  <= pkt_len;
         len_q  <= pkt_len;
      end else if (word_we) begin
         rem_q <= rem_q - LEN_W'(1);
         if (last_word) open_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (start_ok && ep_periodic) begin
         gate_q <= 1'b1;
      end else if (xfer_done || flush) begin
         gate_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= ADM_IDLE;
         err_q <= 1'b0;
      end else begin
         res_q <= start_ok ? ADM_TAKE : (pkt_start ? ADM_REFUSE : ADM_IDLE);
         err_q <= wr_valid && !flush && !word_we;
      end
   end

   AST_DISABLED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && !ep_enable) |=> pkt_rej);   // R4
   AST_PERIODIC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && ep_periodic && gate_q) |=> pkt_rej);   // R6
   AST_OPEN_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && open_q) |=> pkt_rej);   // R11
   AST_ZLP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && is_zlp && ep_enable && !open_q && !slot_full && !flush
       && !(ep_periodic && gate_q)) |=> pkt_ok);   // R2
   AST_ORPHAN_WORD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !open_q && !flush) |=> wr_err);   // R7
   AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_ok, pkt_rej}));   // R1

endmodule

// File: rtl/txf_drain.sv
module txf_drain #(
   parameter int DEPTH_WORDS = 16,
   localparam int LEN_W = $clog2(DEPTH_WORDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             tx_rd,
   input  logic             slot_empty,
   input  logic [LEN_W-1:0] head_len,
   input  logic             data_empty,
   output logic             data_pop,
   output logic             lq_pop,
   output logic             tx_last
);

   logic [LEN_W-1:0] sent_q;
   logic             avail, rd_go, zlp_head;

   assign avail    = !slot_empty;
   assign zlp_head = (head_len == '0);
   assign rd_go    = tx_rd && avail && !flush;
   assign tx_last  = avail && (zlp_head || ((sent_q + LEN_W'(1)) == head_len));
   assign data_pop = rd_go && !zlp_head;
   assign lq_pop   = rd_go && tx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= '0;
      end else if (flush || lq_pop) begin
         sent_q <= '0;
      end else if (data_pop) begin
         sent_q <= sent_q + LEN_W'(1);
      end
   end

   AST_DRAIN_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      data_pop |-> !data_empty);   // R5
   AST_DRAIN_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (avail && !zlp_head) |-> (sent_q < head_len));   // R5

endmodule

// File: rtl/txf_in_ep.sv
module txf_in_ep
   import txf_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int DEPTH_WORDS = 16,
   parameter int PKT_SLOTS   = 4,
   localparam int LEN_W  = $clog2(DEPTH_WORDS + 1),
   localparam int SCNT_W = $clog2(PKT_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ep_enable,
   input  logic              ep_periodic,
   input  logic              xfer_done,
   input  logic              pkt_start,
   input  logic [LEN_W-1:0]  pkt_len,
   output logic              pkt_ok,
   output logic              pkt_rej,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_err,
   output logic [LEN_W-1:0]  free_words,
   output logic              tx_avail,
   output logic [LEN_W-1:0]  tx_len,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_rd,
   output logic              irq_empty,
   input  logic              irq_clr
);

   generate
      if (WORD_W != WORD_BITS) begin : g_bad_word
         $error("txf_in_ep: free space is counted in 32-bit words");
      end
      if (!is_pow2(DEPTH_WORDS)) begin : g_bad_depth
         $error("txf_in_ep: DEPTH_WORDS must be a power of two >= 2");
      end
      if (!is_pow2(PKT_SLOTS)) begin : g_bad_slots
         $error("txf_in_ep: PKT_SLOTS must be a power of two >= 2");
      end
   endgenerate

   logic             word_we, lq_push, data_pop, lq_pop;
   logic [LEN_W-1:0] lq_push_len, rem_words, d_cnt;
   logic [SCNT_W-1:0] s_cnt;
   logic             d_full, d_empty, s_full, s_empty;
   logic             irq_q;

   assign free_words = LEN_W'(DEPTH_WORDS) - d_cnt - rem_words;
   assign tx_avail   = !s_empty;

   txf_admit #(.DEPTH_WORDS(DEPTH_WORDS)) u_admit (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ep_enable(ep_enable), .ep_periodic(ep_periodic), .xfer_done(xfer_done),
      .pkt_start(pkt_start), .pkt_len(pkt_len), .wr_valid(wr_valid),
      .free_words(free_words), .slot_full(s_full),
      .word_we(word_we), .lq_push(lq_push), .lq_push_len(lq_push_len),
      .rem_words(rem_words), .pkt_ok(pkt_ok), .pkt_rej(pkt_rej), .wr_err(wr_err)
   );

   txf_ring #(.W(WORD_W), .DEPTH(DEPTH_WORDS)) u_data (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(word_we), .push_data(wr_data), .pop(data_pop),
      .head(tx_data), .count(d_cnt), .full(d_full), .empty(d_empty)
   );

   txf_ring #(.W(LEN_W), .DEPTH(PKT_SLOTS)) u_slots (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(lq_push), .push_data(lq_push_len), .pop(lq_pop),
      .head(tx_len), .count(s_cnt), .full(s_full), .empty(s_empty)
   );

   txf_drain #(.DEPTH_WORDS(DEPTH_WORDS)) u_drain (
      .clk(clk), .rst_n(rst_n), .flush(flush), .tx_rd(tx_rd),
      .slot_empty(s_empty), .head_len(tx_len), .data_empty(d_empty),
      .data_pop(data_pop), .lq_pop(lq_pop), .tx_last(tx_last)
   );

   // Empty interrupt: set when the drain removes the last held item.
   logic [LEN_W-1:0]  d_nxt;
   logic [SCNT_W-1:0] s_nxt;
   logic              held_now, empty_set;

   assign d_nxt     = d_cnt + LEN_W'(word_we) - LEN_W'(data_pop);
   assign s_nxt     = s_cnt + SCNT_W'(lq_push) - SCNT_W'(lq_pop);
   assign held_now  = (d_cnt != '0) || (s_cnt != '0);
   assign empty_set = !flush && held_now && (d_nxt == '0) && (s_nxt == '0);
   assign irq_empty = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (empty_set) begin
         irq_q <= 1'b1;
      end else if (irq_clr) begin
         irq_q <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, d_cnt} + {1'b0, rem_words}) <= (LEN_W + 1)'(DEPTH_WORDS));   // R3
   AST_DATA_NOT_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_we && !data_pop) |-> !d_full);   // R1
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_empty && !irq_clr) |=> irq_empty);   // R8
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!tx_avail && free_words == LEN_W'(DEPTH_WORDS)));   // R10
   AST_FLUSH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !irq_empty) |=> !irq_empty);   // R10
   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rd && !tx_avail && !word_we && !flush) |=> $stable(free_words));   // R9

endmodule

// File: tb/txf_in_ep_bench.sv
`timescale 1ns/1ps
module txf_in_ep_bench;
   localparam int DW = 16;
   localparam int LW = $clog2(DW + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic flush = 0, ep_enable = 0, ep_periodic = 0, xfer_done = 0;
   logic pkt_start = 0, wr_valid = 0, tx_rd = 0, irq_clr = 0;
   logic [LW-1:0] pkt_len = '0;
   logic [31:0]   wr_data = '0;
   logic pkt_ok, pkt_rej, wr_err, tx_avail, tx_last, irq_empty;
   logic [LW-1:0] free_words, tx_len;
   logic [31:0]   tx_data;

   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   txf_in_ep #(.WORD_W(32), .DEPTH_WORDS(DW), .PKT_SLOTS(4)) u_txf_in_ep (
      .clk(clk), .rst_n(rst_n), .flush(flush), .ep_enable(ep_enable),
      .ep_periodic(ep_periodic), .xfer_done(xfer_done), .pkt_start(pkt_start),
      .pkt_len(pkt_len), .pkt_ok(pkt_ok), .pkt_rej(pkt_rej), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_err(wr_err), .free_words(free_words),
      .tx_avail(tx_avail), .tx_len(tx_len), .tx_data(tx_data), .tx_last(tx_last),
      .tx_rd(tx_rd), .irq_empty(irq_empty), .irq_clr(irq_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic announce(input int len, input bit exp_ok, input string tag);
      pkt_start = 1'b1;
      pkt_len   = LW'(len);
      step();
      pkt_start = 1'b0;
      chk({tag, " ok"},  {31'd0, pkt_ok},  {31'd0, exp_ok});
      chk({tag, " rej"}, {31'd0, pkt_rej}, {31'd0, !exp_ok});
   endtask

   task automatic put_words(input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         wr_valid = 1'b1;
         wr_data  = base + 32'(i);
         step();
      end
      wr_valid = 1'b0;
   endtask

   task automatic take_pkt(input int len, input logic [31:0] base, input string tag);
      chk({tag, " avail"}, {31'd0, tx_avail}, 32'd1);
      chk({tag, " len"}, 32'(tx_len), 32'(len));
      if (len == 0) begin
         chk({tag, " zlp last"}, {31'd0, tx_last}, 32'd1);
         tx_rd = 1'b1;
         step();
         tx_rd = 1'b0;
      end else begin
         for (int i = 0; i < len; i++) begin
            chk({tag, " data"}, tx_data, base + 32'(i));
            chk({tag, " last"}, {31'd0, tx_last}, {31'd0, i == len - 1});
            tx_rd = 1'b1;
            step();
            tx_rd = 1'b0;
         end
      end
   endtask

   task automatic clear_irq();
      irq_clr = 1'b1;
      step();
      irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R3 reset free", 32'(free_words), 32'(DW));
      chk("R5 reset avail", {31'd0, tx_avail}, 32'd0);
      chk("R8 reset irq", {31'd0, irq_empty}, 32'd0);
      chk("R1 reset ok", {31'd0, pkt_ok}, 32'd0);
   endtask

   task automatic t_basic_queue();
      ep_enable = 1'b1;
      announce(4, 1'b1, "R1 len4");
      chk("R3 reserve", 32'(free_words), 32'(DW - 4));
      put_words(2, 32'hA000_0000);
      chk("R3 partial", 32'(free_words), 32'(DW - 4));
      chk("R9 partial avail", {31'd0, tx_avail}, 32'd0);
      tx_rd = 1'b1;
      step();
      tx_rd = 1'b0;
      chk("R9 idle read free", 32'(free_words), 32'(DW - 4));
      put_words(2, 32'hA000_0002);
      chk("R5 avail", {31'd0, tx_avail}, 32'd1);
      wr_valid = 1'b1;
      wr_data  = 32'hDEAD_BEEF;
      step();
      wr_valid = 1'b0;
      chk("R7 extra word err", {31'd0, wr_err}, 32'd1);
      chk("R7 extra word dropped", 32'(free_words), 32'(DW - 4));
      step();
      chk("R7 err pulse", {31'd0, wr_err}, 32'd0);
      announce(3, 1'b1, "R5 second");
      put_words(3, 32'hB000_0000);
      chk("R3 two pkts", 32'(free_words), 32'(DW - 7));
      take_pkt(4, 32'hA000_0000, "R5 first");
      chk("R8 not yet", {31'd0, irq_empty}, 32'd0);
      take_pkt(3, 32'hB000_0000, "R5 second");
      chk("R8 set", {31'd0, irq_empty}, 32'd1);
      chk("R3 empty free", 32'(free_words), 32'(DW));
   endtask

   task automatic t_irq_race();
      clear_irq();
      chk("R8 cleared", {31'd0, irq_empty}, 32'd0);
      announce(1, 1'b1, "R8 one");
      put_words(1, 32'hC000_0000);
      chk("R8 held", {31'd0, irq_empty}, 32'd0);
      tx_rd   = 1'b1;
      irq_clr = 1'b1;
      step();
      tx_rd   = 1'b0;
      irq_clr = 1'b0;
      chk("R8 set wins", {31'd0, irq_empty}, 32'd1);
      step();
      chk("R8 sticky", {31'd0, irq_empty}, 32'd1);
      clear_irq();
      chk("R8 clr", {31'd0, irq_empty}, 32'd0);
   endtask

   task automatic t_space();
      announce(10, 1'b1, "R1 len10");
      put_words(10, 32'h1000_0000);
      chk("R3 after 10", 32'(free_words), 32'(DW - 10));
      announce(7, 1'b0, "R1 too big");
      chk("R1 nothing stored", 32'(free_words), 32'(DW - 10));
      announce(6, 1'b1, "R1 exact fit");
      put_words(6, 32'h2000_0000);
      chk("R3 full", 32'(free_words), 32'd0);
      announce(0, 1'b1, "R2 zlp at full");
      take_pkt(10, 32'h1000_0000, "R5 ten");
      take_pkt(6, 32'h2000_0000, "R5 six");
      take_pkt(0, 32'h0, "R2 zlp drain");
      chk("R8 after zlp", {31'd0, irq_empty}, 32'd1);
      clear_irq();
      tx_rd = 1'b1;
      step();
      tx_rd = 1'b0;
      chk("R9 empty read avail", {31'd0, tx_avail}, 32'd0);
      chk("R9 empty read free", 32'(free_words), 32'(DW));
      chk("R9 empty read irq", {31'd0, irq_empty}, 32'd0);
   endtask

   task automatic t_slots_flush();
      for (int i = 0; i < 4; i++) announce(0, 1'b1, "R2 zlp slot");
      announce(0, 1'b0, "R1 slots full zlp");
      announce(1, 1'b0, "R1 slots full");
      flush = 1'b1;
      step();
      flush = 1'b0;
      chk("R10 avail", {31'd0, tx_avail}, 32'd0);
      chk("R10 no irq", {31'd0, irq_empty}, 32'd0);
      announce(5, 1'b1, "R10 open");
      put_words(2, 32'h3000_0000);
      flush = 1'b1;
      step();
      flush = 1'b0;
      chk("R10 free", 32'(free_words), 32'(DW));
      wr_valid = 1'b1;
      step();
      wr_valid = 1'b0;
      chk("R10 cancelled", {31'd0, wr_err}, 32'd1);
   endtask

   task automatic t_enable();
      ep_enable = 1'b0;
      announce(2, 1'b0, "R4 disabled");
      ep_enable = 1'b1;
      announce(2, 1'b1, "R4 enabled");
      announce(1, 1'b0, "R11 while open");
      ep_enable = 1'b0;
      wr_valid  = 1'b1;
      wr_data   = 32'hBAD0_0000;
      step();
      wr_valid  = 1'b0;
      chk("R4 word err", {31'd0, wr_err}, 32'd1);
      chk("R4 free kept", 32'(free_words), 32'(DW - 2));
      ep_enable = 1'b1;
      put_words(2, 32'h4000_0000);
      take_pkt(2, 32'h4000_0000, "R4 data");
      clear_irq();
   endtask

   task automatic t_periodic();
      ep_periodic = 1'b1;
      announce(1, 1'b1, "R6 first");
      put_words(1, 32'h5000_0000);
      announce(1, 1'b0, "R6 gated");
      xfer_done = 1'b1;
      step();
      xfer_done = 1'b0;
      announce(1, 1'b1, "R6 reopened");
      put_words(1, 32'h5000_0001);
      take_pkt(1, 32'h5000_0000, "R6 d0");
      take_pkt(1, 32'h5000_0001, "R6 d1");
      announce(1, 1'b0, "R6 still gated");
      flush = 1'b1;
      step();
      flush = 1'b0;
      announce(0, 1'b1, "R10 gate reopened");
      ep_periodic = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic_queue();
      t_irq_race();
      t_space();
      t_slots_flush();
      t_enable();
      t_periodic();
      step();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule